// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds return addresses for a small processor core. When the core takes a call or accepts an interrupt, it raises a push strobe, and the block stores the program-counter value presented with it. When the core executes a return-type instruction, it raises a pop strobe, and the block hands back the most recently stored address in that same cycle. The storage is private to the block. Nothing outside can read or load the stack pointer.

The stack is circular and never saturates. The seventeenth push with no pop in between overwrites the oldest entry. Software learns about the stack's state only through a single availability flag:

- The flag drops while the pointer sits on the last slot.
- The flag is latched low, until the next reset, once a push carries the pointer from the last slot back to slot zero.
- There is no underflow flag. A pop taken from slot zero lands the pointer on the last slot, so the flag drops exactly as it does for a full stack.

Push and pop are plain single-cycle strobes with no handshake. The stack is always able to accept either one. Raising both strobes together is illegal; if it happens, the push wins and the pop is dropped.

Top module: `retaddr_stack`

## Requirements
- R1: After reset the pointer is 0, every entry holds zero and `stk_avail_o` is 1.
- R2: A push stores `push_pc_i` in the entry at the pointer and then advances the pointer by one, modulo 16.
- R3: `top_pc_o` always shows the entry at (pointer - 1) mod 16. During a pop cycle it therefore carries the returned address, and at the clock edge the pointer steps back by one.
- R4: `stk_avail_o` is 0 whenever the pointer equals 15, and it is 0 after fifteen pushes from reset.
- R5: A pop that moves the pointer from 15 to 14, with no lock set, sets `stk_avail_o` to 1 again.
- R6: A push taken while the pointer is 15 wraps the pointer to 0 and latches `stk_avail_o` low. Later pushes and pops do not release it.
- R7: After seventeen pushes with no pop, the first entry has been overwritten. Seventeen pops then return pushes 17, 16, down to 2, and then push 17 again.
- R8: A pop straight after reset returns entry 15 and clears `stk_avail_o`. A push that follows it, before any other pop, latches the flag low.
- R9: When push and pop are raised in the same cycle, the push is performed and the pop is ignored, so the stored value becomes the next one returned.
- R10: Reset releases the latched-low availability flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe (call or interrupt accept) |
| pop_i | input | 1 | Pop strobe (return) |
| push_pc_i | input | 16 | Address stored on a push |
| top_pc_o | output | 16 | Entry at pointer minus one; the returned address during a pop |
| stk_avail_o | output | 1 | Stack-available status flag |

## Verification
The assertions assume the following about the inputs:
- The two strobes are synchronous to the clock and are never unknown once reset is released.
- A cycle with both strobes high is legal input and must behave as a push alone.

The stimulus follows these rules:
- It changes inputs shortly after a rising edge and holds each strobe for exactly one cycle.
- It returns to idle between operations.
- It deliberately issues one combined push-and-pop cycle to exercise the priority rule.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int unsigned STK_DEPTH = 16;
  localparam int unsigned STK_WIDTH = 16;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op_i,
  output logic [AW-1:0] ptr_o,
  output logic          avail_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic [AW-1:0] ptr_q;
  logic          lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          ptr_q <= ptr_q + ONE;
          if (ptr_q == LAST) lock_q <= 1'b1;
        end
        OP_POP:  ptr_q <= ptr_q - ONE;
        default: ;
      endcase
    end
  end

  assign ptr_o   = ptr_q;
  assign avail_o = (ptr_q != LAST) && !lock_q;

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_PUSH |=> (ptr_q - $past(ptr_q)) == ONE); // R2
  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_POP |=> ($past(ptr_q) - ptr_q) == ONE); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R6
  AST_ROLL_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH && ptr_q == LAST) |=> (!avail_o && ptr_q == '0)); // R6
  AST_AVAIL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail_o) |-> $past(op_i == OP_POP)); // R5
endmodule

// File: rtl/rstk_mem.sv
module rstk_mem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
    end else if (wr_en_i) begin
      slot_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> slot_q[$past(wr_idx_i)] == $past(wr_data_i)); // R2
endmodule

// File: rtl/retaddr_stack.sv
module retaddr_stack
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  parameter int unsigned WIDTH = STK_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_pc_i,
  output logic [WIDTH-1:0] top_pc_o,
  output logic             stk_avail_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  stk_op_e       op;
  logic [AW-1:0] ptr;
  logic [AW-1:0] top_idx;

  // push has priority over a simultaneous pop (R9)
  always_comb begin
    if (push_i)     op = OP_PUSH;
    else if (pop_i) op = OP_POP;
    else            op = OP_IDLE;
  end

  assign top_idx = ptr - AW'(1);

  rstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .ptr_o   (ptr),
    .avail_o (stk_avail_o)
  );

  rstk_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (op == OP_PUSH),
    .wr_idx_i  (ptr),
    .wr_data_i (push_pc_i),
    .rd_idx_i  (top_idx),
    .rd_data_o (top_pc_o)
  );

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> top_pc_o == $past(push_pc_i)); // R9
endmodule

// File: tb/test_retaddr_stack.sv
`timescale 1ns/1ps
module test_retaddr_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0;
  logic        pop_i = 1'b0;
  logic [15:0] push_pc_i = '0;
  logic [15:0] top_pc_o;
  logic        stk_avail_o;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  retaddr_stack i_retaddr_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_pc_i(push_pc_i), .top_pc_o(top_pc_o), .stk_avail_o(stk_avail_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare every real pop against the scoreboard
  always @(negedge clk) begin
    if (rst_n && pop_i && !push_i) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3: unexpected pop, actual %h expected none", top_pc_o);
      end else begin
        check(tag_q.pop_front(), top_pc_o, exp_q.pop_front());
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic do_push(input logic [15:0] v);
    @(posedge clk); #1 push_i = 1'b1; push_pc_i = v;
    @(posedge clk); #1 push_i = 1'b0;
  endtask

  task automatic do_pop(input logic [15:0] exp, input string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    @(posedge clk); #1 pop_i = 1'b1;
    @(posedge clk); #1 pop_i = 1'b0;
  endtask

  task automatic do_both(input logic [15:0] v);
    @(posedge clk); #1 push_i = 1'b1; pop_i = 1'b1; push_pc_i = v;
    @(posedge clk); #1 push_i = 1'b0; pop_i = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    check("R1", 16'(stk_avail_o), 16'd1);
    check("R1", top_pc_o, 16'h0000);

    // R2/R3: plain LIFO order
    do_push(16'h1234); do_push(16'hBEEF); do_push(16'h0F0F);
    do_pop(16'h0F0F, "R3"); do_pop(16'hBEEF, "R2"); do_pop(16'h1234, "R2");
    check("R2", 16'(stk_avail_o), 16'd1);

    // R4/R5: fill to the last slot, then step back
    do_reset();
    for (int i = 0; i < 15; i++) begin
      do_push(16'h0100 + 16'(i));
      if (i == 13) check("R4", 16'(stk_avail_o), 16'd1);
    end
    check("R4", 16'(stk_avail_o), 16'd0);
    do_pop(16'h010E, "R5");
    check("R5", 16'(stk_avail_o), 16'd1);

    // R6/R7: roll over and overwrite
    do_reset();
    for (int i = 0; i < 17; i++) begin
      do_push(16'hA000 + 16'(i));
      if (i == 15) check("R6", 16'(stk_avail_o), 16'd0);
    end
    for (int i = 16; i >= 1; i--) do_pop(16'hA000 + 16'(i), "R7");
    do_pop(16'hA010, "R7");
    check("R6", 16'(stk_avail_o), 16'd0);

    // R10: reset releases the lock
    do_reset();
    check("R10", 16'(stk_avail_o), 16'd1);

    // R8: underflow then push
    do_pop(16'h0000, "R8");
    check("R8", 16'(stk_avail_o), 16'd0);
    do_push(16'h55AA);
    check("R8", 16'(stk_avail_o), 16'd0);
    do_pop(16'h55AA, "R8");
    do_pop(16'h0000, "R8");
    check("R6", 16'(stk_avail_o), 16'd0);

    // R9: simultaneous push and pop
    do_reset();
    do_push(16'h1111);
    do_both(16'h2222);
    check("R9", top_pc_o, 16'h2222);
    do_pop(16'h2222, "R9");
    do_pop(16'h1111, "R9");
    check("R9", 16'(stk_avail_o), 16'd1);

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R3: actual %0d pending expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule